// File: doc/BRIEF.md
# Wave-Barrier Block Dispatcher

This block hands numbered work blocks to an array of processing clusters. Each cluster holds several cores, and each core has a fixed number of resident block slots. A launch request carries the total number of blocks in the kernel. The dispatcher then issues them in waves. A wave fills every slot in the array, or holds only the blocks that remain.

Within a wave, blocks go out in ascending index order, one per clock. Consecutive indices are spread across the clusters in rotation, so cluster `c` receives blocks `c`, `c+NCL`, `c+2*NCL` and so on.

The slots report completion with one-clock retire pulses. The dispatcher holds the next wave back until every block of the current wave has retired. A wave therefore lasts as long as its slowest block, even if most slots sit idle for most of that time. When the last block of the last wave retires, a done flag rises and stays high until the next launch. A retire pulse for a slot that holds no block changes nothing and raises a one-clock error pulse.

Top module: `wave_dispatch`

## Requirements
- R1: After reset, `disp_valid`, `kernel_done` and `proto_err` are all low.
- R2: Within a wave, blocks are issued on consecutive clocks in ascending index order, and the first block of a kernel has index 0.
- R3: With k = block index mod wave size, the block goes to cluster k mod NCL.
- R4: With j = k / NCL, the block goes to core j mod CPC and to slot j / CPC of that core.
- R5: The wave size is NCL*CPC*SPC. No block of the next wave is issued while any block of the current wave has not retired. The first block of the next wave appears exactly 3 clocks after the clock on which the final retire pulse of the previous wave was driven.
- R6: When the block count is not a multiple of the wave size, the last wave issues only the remaining blocks. No dispatch goes beyond the requested count.
- R7: An accepted launch clears `kernel_done` on the next clock. `kernel_done` rises once the last block retires. A launch with a count of 0 sets it on the next clock and issues nothing.
- R8: A launch pulse that arrives while a kernel is still running is ignored. The running kernel keeps its count and order.
- R9: The retire bit for a slot is at index (cluster*CPC+core)*SPC+slot. A retire pulse on a slot that is not busy has no effect on dispatch or on the busy state, and it raises `proto_err` for exactly one clock, on the clock after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Start-kernel request pulse |
| launch_blocks | input | CNT_W | Number of blocks in the kernel |
| retire | input | NCL*CPC*SPC | Per-slot completion pulses |
| disp_valid | output | 1 | A block is dispatched this clock |
| disp_block | output | CNT_W | Index of the dispatched block |
| disp_cluster | output | max(1,clog2(NCL)) | Target cluster |
| disp_core | output | max(1,clog2(CPC)) | Target core within the cluster |
| disp_slot | output | max(1,clog2(SPC)) | Target slot within the core |
| kernel_done | output | 1 | All blocks of the last kernel have retired |
| proto_err | output | 1 | Retire seen on an idle slot |

## Verification
The bench builds the block with 4 clusters of 3 cores and 2 slots per core, which gives a 24-slot wave. This configuration exercises a cluster count of 4, a core count of 3 that is not a power of two, and more than one slot per core, so every digit of the rotation in R3 and R4 wraps. Because the wave is short, a 50-block kernel runs two full waves and a 2-block partial wave. Single long-running blocks placed in chosen waves show that the barrier waits for the slowest block, while the slots that retire early stay empty.

// File: rtl/wave_dispatch.sv
module wave_dispatch #(
  parameter int NCL   = 8,
  parameter int CPC   = 2,
  parameter int SPC   = 8,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  logic [CNT_W-1:0]     launch_blocks,
  input  logic [NCL*CPC*SPC-1:0] retire,
  output logic                 disp_valid,
  output logic [CNT_W-1:0]     disp_block,
  output logic [(NCL>1?$clog2(NCL):1)-1:0] disp_cluster,
  output logic [(CPC>1?$clog2(CPC):1)-1:0] disp_core,
  output logic [(SPC>1?$clog2(SPC):1)-1:0] disp_slot,
  output logic                 kernel_done,
  output logic                 proto_err
);
  localparam int NSLOT = NCL*CPC*SPC;
  localparam int CLW = NCL > 1 ? $clog2(NCL) : 1;
  localparam int COW = CPC > 1 ? $clog2(CPC) : 1;
  localparam int SLW = SPC > 1 ? $clog2(SPC) : 1;

  typedef enum logic [1:0] {IDLE, ISSUE, DRAIN} st_t;
  st_t st;

  logic [CNT_W-1:0] total, next_blk;
  logic [CLW-1:0]   cl;
  logic [COW-1:0]   co;
  logic [SLW-1:0]   sl;
  logic [NSLOT-1:0] busy, set_vec;

  wire cl_last  = (cl == CLW'(NCL-1));
  wire co_last  = (co == COW'(CPC-1));
  wire sl_last  = (sl == SLW'(SPC-1));
  wire wave_end = cl_last && co_last && sl_last;
  wire kern_end = (next_blk + CNT_W'(1)) == total;
  int  slot_id;

  assign slot_id = (int'(cl)*CPC + int'(co))*SPC + int'(sl);

  always_comb begin
    set_vec = '0;
    if (st == ISSUE) set_vec[slot_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= IDLE;
      busy         <= '0;
      total        <= '0;
      next_blk     <= '0;
      cl           <= '0;
      co           <= '0;
      sl           <= '0;
      disp_valid   <= 1'b0;
      disp_block   <= '0;
      disp_cluster <= '0;
      disp_core    <= '0;
      disp_slot    <= '0;
      kernel_done  <= 1'b0;
      proto_err    <= 1'b0;
    end else begin
      busy       <= (busy & ~retire) | set_vec;
      proto_err  <= |(retire & ~busy);
      disp_valid <= 1'b0;
      case (st)
        IDLE: if (launch) begin
          kernel_done <= (launch_blocks == '0);
          total       <= launch_blocks;
          next_blk    <= '0;
          cl          <= '0;
          co          <= '0;
          sl          <= '0;
          if (launch_blocks != '0) st <= ISSUE;
        end
        ISSUE: begin
          disp_valid   <= 1'b1;
          disp_block   <= next_blk;
          disp_cluster <= cl;
          disp_core    <= co;
          disp_slot    <= sl;
          next_blk     <= next_blk + CNT_W'(1);
          cl           <= cl_last ? '0 : cl + CLW'(1);
          if (cl_last) begin
            co <= co_last ? '0 : co + COW'(1);
            if (co_last) sl <= sl_last ? '0 : sl + SLW'(1);
          end
          if (kern_end || wave_end) st <= DRAIN;
        end
        DRAIN: if (busy == '0) begin
          cl <= '0;
          co <= '0;
          sl <= '0;
          if (next_blk == total) begin
            kernel_done <= 1'b1;
            st          <= IDLE;
          end else begin
            st <= ISSUE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module wave_dispatch_chk #(
  parameter int NCL   = 8,
  parameter int CPC   = 2,
  parameter int SPC   = 8,
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCL*CPC*SPC-1:0] retire,
  input logic [NCL*CPC*SPC-1:0] busy,
  input logic                 disp_valid,
  input logic [CNT_W-1:0]     disp_block,
  input logic [(NCL>1?$clog2(NCL):1)-1:0] disp_cluster,
  input logic [(CPC>1?$clog2(CPC):1)-1:0] disp_core,
  input logic [(SPC>1?$clog2(SPC):1)-1:0] disp_slot,
  input logic                 kernel_done,
  input logic                 proto_err
);
  // R2
  consecutive_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && $past(disp_valid) |-> disp_block == $past(disp_block) + CNT_W'(1));
  // R3
  cluster_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && $past(disp_valid) |->
      int'(disp_cluster) == (int'($past(disp_cluster)) + 1) % NCL);
  // R4
  target_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> int'(disp_cluster) < NCL && int'(disp_core) < CPC && int'(disp_slot) < SPC);
  // R5
  wave_barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !$past(disp_valid) |-> $past(busy) == '0);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kernel_done |-> busy == '0 && !disp_valid);
  // R9
  no_spurious_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire & ~busy) == '0 |=> !proto_err);
endmodule

bind wave_dispatch wave_dispatch_chk #(.NCL(NCL), .CPC(CPC), .SPC(SPC), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire(retire), .busy(busy),
  .disp_valid(disp_valid), .disp_block(disp_block), .disp_cluster(disp_cluster),
  .disp_core(disp_core), .disp_slot(disp_slot), .kernel_done(kernel_done),
  .proto_err(proto_err));

// File: tb/wave_dispatch_tb.sv
`timescale 1ns/1ps
module wave_dispatch_tb;
  localparam int NCL = 4, CPC = 3, SPC = 2, CNT_W = 16;
  localparam int WAVE = NCL*CPC*SPC;

  logic clk = 0, rst_n = 0, launch = 0;
  logic [CNT_W-1:0] launch_blocks = '0;
  logic [WAVE-1:0] retire = '0;
  logic disp_valid, kernel_done, proto_err;
  logic [CNT_W-1:0] disp_block;
  logic [1:0] disp_cluster, disp_core;
  logic [0:0] disp_slot;

  wave_dispatch #(.NCL(NCL), .CPC(CPC), .SPC(SPC), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_blocks(launch_blocks),
    .retire(retire), .disp_valid(disp_valid), .disp_block(disp_block),
    .disp_cluster(disp_cluster), .disp_core(disp_core), .disp_slot(disp_slot),
    .kernel_done(kernel_done), .proto_err(proto_err));

  always #2.5 clk = ~clk;

  typedef struct packed { int blk; int cl; int co; int sl; } exp_t;
  exp_t exp_q[$];
  int tmr[WAVE];
  int n_checks = 0, n_fail = 0;
  int cyc = 0, retired_cnt = 0, disp_cnt = 0;
  int last_ret_cyc = 0, last_disp_cyc = 0;
  int long_a = -1, long_b = -1;
  bit err_expect = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    logic [WAVE-1:0] r;
    cyc++;
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 0);
      finish_run();
    end
    if (err_expect) begin
      check(proto_err == 1'b1, "R9 error pulse", int'(proto_err), 1);
      err_expect = 0;
    end else if (proto_err) begin
      check(0, "R9 spurious error", 1, 0);
    end
    if (disp_valid) begin
      int b, s, d;
      exp_t e;
      b = int'(disp_block);
      if (exp_q.size() == 0) begin
        check(0, "R6 unexpected dispatch", b, -1);
      end else begin
        e = exp_q.pop_front();
        check(b == e.blk, "R2 block order", b, e.blk);
        check(int'(disp_cluster) == e.cl, "R3 cluster", int'(disp_cluster), e.cl);
        check(int'(disp_core) == e.co && int'(disp_slot) == e.sl, "R4 core/slot",
              int'(disp_core)*10 + int'(disp_slot), e.co*10 + e.sl);
      end
      check(retired_cnt >= (b / WAVE) * WAVE, "R5 barrier", retired_cnt, (b / WAVE) * WAVE);
      if (b % WAVE == 0 && b > 0)
        check(cyc - last_ret_cyc == 3, "R5 wave restart latency", cyc - last_ret_cyc, 3);
      else if (b % WAVE != 0)
        check(cyc - last_disp_cyc == 1, "R2 one per clock", cyc - last_disp_cyc, 1);
      last_disp_cyc = cyc;
      disp_cnt++;
      s = (int'(disp_cluster)*CPC + int'(disp_core))*SPC + int'(disp_slot);
      if (s < WAVE) begin
        check(tmr[s] == 0, "R5 slot free", tmr[s], 0);
        d = (b == long_a || b == long_b) ? 40 : 2 + (b % 3);
        tmr[s] = d + 1;
      end
    end
    r = '0;
    for (int i = 0; i < WAVE; i++) begin
      if (tmr[i] > 0) begin
        tmr[i]--;
        if (tmr[i] == 0) begin
          r[i] = 1'b1;
          retired_cnt++;
          last_ret_cyc = cyc;
        end
      end
    end
    retire = r;
  end

  task automatic push_expected(input int n);
    for (int b = 0; b < n; b++) begin
      exp_t e;
      int k, j;
      k = b % WAVE;
      j = k / NCL;
      e.blk = b; e.cl = k % NCL; e.co = j % CPC; e.sl = j / CPC;
      exp_q.push_back(e);
    end
  endtask

  task automatic run_kernel(input int n, input int la, input int lb, input bit mid);
    int guard;
    long_a = la; long_b = lb;
    @(negedge clk); #1;
    retired_cnt = 0; disp_cnt = 0;
    push_expected(n);
    launch = 1; launch_blocks = CNT_W'(n);
    @(negedge clk); #1;
    launch = 0;
    check(kernel_done == 1'b0, "R7 done cleared", int'(kernel_done), 0);
    if (mid) begin
      repeat (10) @(negedge clk);
      #1; launch = 1; launch_blocks = 16'd3;
      @(negedge clk); #1; launch = 0;
    end
    guard = 0;
    while (!kernel_done && guard < 20000) begin
      @(negedge clk); guard++;
    end
    #1;
    check(kernel_done == 1'b1, "R7 done set", int'(kernel_done), 1);
    check(disp_cnt == n, mid ? "R8 ignored launch / R6 count" : "R6 dispatch count", disp_cnt, n);
    check(retired_cnt == n, "R7 all retired before done", retired_cnt, n);
    check(exp_q.size() == 0, "R6 nothing left", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    for (int i = 0; i < WAVE; i++) tmr[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    check(disp_valid == 0, "R1 disp_valid", int'(disp_valid), 0);
    check(kernel_done == 0, "R1 kernel_done", int'(kernel_done), 0);
    check(proto_err == 0, "R1 proto_err", int'(proto_err), 0);
    rst_n = 1;
    @(negedge clk); #1;
    launch = 1; launch_blocks = '0;
    @(negedge clk); #1;
    launch = 0;
    check(kernel_done == 1'b1, "R7 zero count done", int'(kernel_done), 1);
    repeat (3) @(negedge clk);
    check(disp_cnt == 0, "R7 zero count no dispatch", disp_cnt, 0);
    run_kernel(WAVE, 0, -1, 0);
    run_kernel(50, 5, 30, 1);
    run_kernel(1, -1, -1, 0);
    run_kernel(13, 12, -1, 0);
    @(negedge clk); #1;
    retire[7] = 1'b1;
    err_expect = 1;
    repeat (3) @(negedge clk);
    #1;
    check(disp_valid == 0 && kernel_done == 1, "R9 idle retire no effect",
          int'(disp_valid), 0);
    run_kernel(WAVE + 1, WAVE, -1, 0);
    finish_run();
  end
endmodule